// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside an SDRAM command sequencer and turns one read or write start into a stream of column addresses, one per clock, for every beat of the burst. A mode-register-set command loads three settings from the address-bus bits: the burst length, the wrap ordering and a write policy. The ordering is either sequential, where the address counts up modulo the length, or interleaved, where the start offset is XORed with the beat index. The write policy can force every write to a single beat while reads keep the programmed length.

Only the low log2(length) column bits move during a burst. The upper bits stay at the value of the starting column, so the burst wraps inside an aligned block. Each beat is flagged as valid, and the first and last beats are marked. The sequencer can cut a burst short at any time by issuing a new start.

Top module: `burst_col_gen`

## Requirements
- R1: On `mrs_valid`, `mode_bits[2:0]` selects the burst length: 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8. Every other code gives 1 beat.
- R2: On `mrs_valid`, `mode_bits[3]` selects the ordering: 0 = sequential, 1 = interleaved.
- R3: In sequential order, beat i drives low bits (s + i) mod L, where s is the start offset within the aligned block of L columns. For example, L=4 with s=2 gives 2,3,0,1.
- R4: In interleaved order, beat i drives low bits s XOR i. For example, L=8 with s=3 gives 3,2,1,0,7,6,5,4.
- R5: Column bits at and above bit log2(L) hold the starting column's value on every beat of a burst.
- R6: When `mode_bits[9]` was 1 at the last mode set, every write lasts exactly one beat and reads use the programmed length. When it was 0, writes also use the programmed length.
- R7: `col_valid` is high for exactly L consecutive cycles. `first_beat` is set on the first of these cycles only and `last_beat` on the final one only.
- R8: A start that is accepted shows its first beat in the cycle after it is sampled. If a burst is active, that burst is aborted.
- R9: A start sampled in the same cycle as `mrs_valid` is ignored, and the mode update still takes effect.
- R10: After reset `col_valid` is low, and the mode is length 1, sequential order and normal write policy.
- R11: With L=2 both orderings produce the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mrs_valid | input | 1 | Mode-register-set command strobe |
| mode_bits | input | MODE_W | Address-bus bits captured on mode set |
| start_valid | input | 1 | Read or write burst start strobe |
| is_write | input | 1 | 1 = write start, 0 = read start |
| start_col | input | COL_W | Starting column of the burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being driven this cycle |
| first_beat | output | 1 | Current beat is the first of its burst |
| last_beat | output | 1 | Current beat is the last of its burst |

## Verification
The assertions assume that `start_col` is stable only in the cycle in which `start_valid` is high. They also assume that the strobes are single-cycle pulses that the sequencer may raise at any time, including in the middle of a burst or together with each other. The bench drives every input on the falling edge, so each strobe is seen at exactly one rising edge. Between bursts it waits long enough for the block to go idle, except in the deliberate abort and collision cases. It also keeps `start_col` within `COL_W` bits, so that the upper-bit check compares meaningful values.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int MAX_LG = 3;
    localparam int LG_W   = 2;
    localparam int IDX_W  = MAX_LG;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic [LG_W-1:0] len_lg;
        order_e          order;
        logic            wr_single;
    } mode_t;

    function automatic logic [IDX_W-1:0] last_index(input logic [LG_W-1:0] lg);
        logic [IDX_W:0] full;
        full = ({{IDX_W{1'b0}}, 1'b1} << lg) - 1'b1;
        return full[IDX_W-1:0];
    endfunction

    function automatic logic [LG_W-1:0] decode_len(input logic [2:0] code);
        case (code)
            3'b001:  return 2'd1;
            3'b010:  return 2'd2;
            3'b011:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_pkg::*;
#(
    parameter int MODE_W      = 12,
    parameter int ORDER_BIT   = 3,
    parameter int WSINGLE_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_valid,
    input  logic [MODE_W-1:0] mode_bits,
    output mode_t             mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.len_lg    <= '0;
            mode_q.order     <= ORD_SEQ;
            mode_q.wr_single <= 1'b0;
        end else if (mrs_valid) begin
            mode_q.len_lg    <= decode_len(mode_bits[2:0]);
            mode_q.order     <= order_e'(mode_bits[ORDER_BIT]);
            mode_q.wr_single <= mode_bits[WSINGLE_BIT];
        end
    end

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(mrs_valid) |-> $stable(mode_q));
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LG_W-1:0]  lg_in,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic [LG_W-1:0]  lg_q,
    output logic             at_last
);
    assign at_last = active && (idx == last_index(lg_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            lg_q   <= '0;
        end else if (take) begin
            active <= 1'b1;
            idx    <= '0;
            lg_q   <= lg_in;
        end else if (active) begin
            if (at_last) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
        active |-> idx <= last_index(lg_q));
    p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
        active && !at_last && !take |=> active && idx == $past(idx) + 1'b1);
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [IDX_W-1:0] idx,
    input  logic [LG_W-1:0]  lg,
    input  order_e           order,
    output logic [COL_W-1:0] col
);
    logic [IDX_W-1:0] msk, low, stepped, new_low;

    always_comb begin
        msk     = last_index(lg);
        low     = base_col[IDX_W-1:0];
        stepped = (order == ORD_INTLV) ? (low ^ idx) : (low + idx);
        new_low = (low & ~msk) | (stepped & msk);
        col     = {base_col[COL_W-1:IDX_W], new_low};
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int COL_W       = 10,
    parameter int MODE_W      = 12,
    parameter int ORDER_BIT   = 3,
    parameter int WSINGLE_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_valid,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              start_valid,
    input  logic              is_write,
    input  logic [COL_W-1:0]  start_col,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              first_beat,
    output logic              last_beat
);
    mode_t            mode_q;
    logic             take;
    logic [LG_W-1:0]  eff_lg, lg_q;
    logic             active, at_last;
    logic [IDX_W-1:0] idx;
    logic [COL_W-1:0] base_q;
    order_e           order_q;

    burst_mode_reg #(.MODE_W(MODE_W), .ORDER_BIT(ORDER_BIT), .WSINGLE_BIT(WSINGLE_BIT)) u_mode (
        .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mode_bits(mode_bits), .mode_q(mode_q)
    );

    assign take   = start_valid && !mrs_valid;
    assign eff_lg = (is_write && mode_q.wr_single) ? '0 : mode_q.len_lg;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            order_q <= ORD_SEQ;
        end else if (take) begin
            base_q  <= start_col;
            order_q <= mode_q.order;
        end
    end

    burst_beat_seq u_seq (
        .clk(clk), .rst(rst), .take(take), .lg_in(eff_lg),
        .active(active), .idx(idx), .lg_q(lg_q), .at_last(at_last)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_col(base_q), .idx(idx), .lg(lg_q), .order(order_q), .col(col_out)
    );

    assign col_valid  = active;
    assign first_beat = active && (idx == '0);
    assign last_beat  = at_last;

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        start_valid && !mrs_valid |=> col_valid && first_beat && col_out == $past(start_col));
    p_mrs_block_r9: assert property (@(posedge clk) disable iff (rst)
        mrs_valid && start_valid && (!col_valid || last_beat) |=> !col_valid);
    p_upper_r5: assert property (@(posedge clk) disable iff (rst)
        col_valid && !first_beat |->
            col_out[COL_W-1:IDX_W] == $past(col_out[COL_W-1:IDX_W]));
    p_end_r7: assert property (@(posedge clk) disable iff (rst)
        last_beat |=> !col_valid || first_beat);
    p_cont_r7: assert property (@(posedge clk) disable iff (rst)
        col_valid && !last_beat && !(start_valid && !mrs_valid) |=> col_valid && !first_beat);
    p_first_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (first_beat || last_beat) |-> col_valid);
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    localparam int COL_W  = 10;
    localparam int MODE_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mrs_valid = 1'b0;
    logic [MODE_W-1:0] mode_bits = '0;
    logic              start_valid = 1'b0;
    logic              is_write = 1'b0;
    logic [COL_W-1:0]  start_col = '0;
    logic [COL_W-1:0]  col_out;
    logic              col_valid, first_beat, last_beat;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W), .MODE_W(MODE_W)) dut_i (
        .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mode_bits(mode_bits),
        .start_valid(start_valid), .is_write(is_write), .start_col(start_col),
        .col_out(col_out), .col_valid(col_valid), .first_beat(first_beat), .last_beat(last_beat)
    );

    typedef struct {
        int    col;
        bit    f;
        bit    l;
        string tag;
    } beat_t;

    beat_t exp_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int i, input int len, input bit intl);
        int off, base;
        off  = s % len;
        base = s - off;
        return intl ? base + (off ^ i) : base + ((off + i) % len);
    endfunction

    function automatic logic [MODE_W-1:0] mk_mode(input int code, input bit intl, input bit ws);
        logic [MODE_W-1:0] m;
        m = '0;
        m[2:0] = code[2:0];
        m[3]   = intl;
        m[9]   = ws;
        return m;
    endfunction

    task automatic set_mode(input logic [MODE_W-1:0] m);
        @(negedge clk);
        mrs_valid = 1'b1;
        mode_bits = m;
        @(negedge clk);
        mrs_valid = 1'b0;
    endtask

    task automatic start_burst(input int col, input bit wr, input int len, input bit intl,
                               input int keep, input string tag);
        int n;
        @(negedge clk);
        start_valid = 1'b1;
        is_write    = wr;
        start_col   = col[COL_W-1:0];
        n = (keep < 0) ? len : keep;
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.col = exp_col(col, i, len, intl);
            b.f   = (i == 0);
            b.l   = (i == len - 1);
            b.tag = tag;
            exp_q.push_back(b);
        end
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && col_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 R9 unexpected beat", int'(col_out), -1);
            end else begin
                beat_t b;
                b = exp_q.pop_front();
                chk(int'(col_out) == b.col, {b.tag, " col"}, int'(col_out), b.col);
                chk(first_beat == b.f && last_beat == b.l, {b.tag, " R7 flags"},
                    {first_beat, last_beat}, {b.f, b.l});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        chk(!col_valid && !first_beat && !last_beat, "R10 reset outputs",
            {col_valid, first_beat, last_beat}, 0);

        start_burst('h2A6, 1'b0, 1, 1'b0, -1, "R10 default length");
        idle(3);

        set_mode(mk_mode(2, 1'b0, 1'b0));
        start_burst('h012, 1'b0, 4, 1'b0, -1, "R1 R3 seq len4");
        idle(6);
        set_mode(mk_mode(3, 1'b0, 1'b0));
        start_burst('h015, 1'b0, 8, 1'b0, -1, "R1 R3 seq len8");
        idle(10);
        start_burst('h3FD, 1'b1, 8, 1'b0, -1, "R5 R6 upper bits");
        idle(10);

        set_mode(mk_mode(3, 1'b1, 1'b0));
        start_burst('h003, 1'b0, 8, 1'b1, -1, "R2 R4 intlv len8");
        idle(10);
        set_mode(mk_mode(2, 1'b1, 1'b0));
        start_burst('h1A1, 1'b0, 4, 1'b1, -1, "R2 R4 intlv len4");
        idle(6);

        set_mode(mk_mode(1, 1'b1, 1'b0));
        start_burst('h0F7, 1'b0, 2, 1'b1, -1, "R11 len2 intlv");
        idle(4);
        set_mode(mk_mode(1, 1'b0, 1'b0));
        start_burst('h0F7, 1'b0, 2, 1'b1, -1, "R11 len2 seq");
        idle(4);

        set_mode(mk_mode(5, 1'b0, 1'b0));
        start_burst('h044, 1'b0, 1, 1'b0, -1, "R1 reserved code");
        idle(3);

        set_mode(mk_mode(2, 1'b0, 1'b1));
        start_burst('h10E, 1'b1, 1, 1'b0, -1, "R6 single write");
        idle(3);
        start_burst('h10E, 1'b0, 4, 1'b0, -1, "R6 read keeps length");
        idle(6);

        set_mode(mk_mode(3, 1'b0, 1'b0));
        start_burst('h020, 1'b0, 8, 1'b0, 2, "R8 aborted burst");
        start_burst('h05B, 1'b0, 8, 1'b0, -1, "R8 new burst");
        idle(10);

        @(negedge clk);
        mrs_valid   = 1'b1;
        mode_bits   = mk_mode(2, 1'b1, 1'b0);
        start_valid = 1'b1;
        start_col   = 'h077;
        @(negedge clk);
        mrs_valid   = 1'b0;
        start_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(!col_valid, "R9 start ignored", col_valid, 0);
            @(negedge clk);
        end
        start_burst('h076, 1'b0, 4, 1'b1, -1, "R9 mode still updated");
        idle(6);

        chk(exp_q.size() == 0, "R7 all beats seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule